// File: doc/BRIEF.md
# Byte-Parity Banked Word Memory Controller

This controller answers a simple synchronous CPU bus with 16-bit words held in an array of eight banks. Each stored entry carries two extra check bits, one even-parity bit per byte. The word address picks a bank and a row within it. The write enable and the write data go to every bank at once, and only the one bank whose row strobe is raised takes the access. Reads are steered the same way. A bank slot with no storage floats high, so it reads back as all ones.

A single control/status register sits at one of sixteen word addresses in the I/O page, chosen by a static select input. The register holds an error flag, an enable that turns parity errors into a bus error, a diagnostic bit that stores both check bits inverted, and a view of the captured failing address. A control bit picks whether that view shows the low or the high part of the address. Every request is answered on the next clock. Reset, which stands for power-up and bus INIT, clears the register.

Top module: `pmc_ctrl`

## Requirements
- R1: A word written to a populated bank reads back unchanged, with `ack` high one clock after the request and `bus_err` low.
- R2: While the diagnostic bit (CSR bit 2) is clear, every written word is stored with correct even parity per byte, so reading it back gives no parity error for any data pattern.
- R3: While CSR bit 2 is set, both check bits are stored inverted, so a later read of that word (data still correct) is a parity error.
- R4: Each access raises at most one bank row strobe, so a write to one bank never changes the same row of another bank.
- R5: A read of a bank slot at or above POP_BANKS, an odd byte address, or any address outside the memory span (MEM_BASE up to MEM_BASE + 2·BANKS·BANK_WORDS) returns 16'hFFFF, raises no `bus_err` and does not set the error flag. Writes there change no stored word.
- R6: The CSR answers only at byte address 22'h3FF440 + 2·`csr_sel` (I/O-page offset 172100 octal plus the select). A neighbouring select address behaves as unmapped and leaves the CSR untouched.
- R7: CSR layout: bit 15 error flag, bit 14 high-address view, bits 11..5 error address field, bit 2 invert-parity, bit 0 bus-error enable. Bits 13, 12, 4, 3 and 1 read as zero. Software writes all defined bits. A write to the field loads address bits 21..18 from bits 8..5 when the written bit 14 is 1, else bits 17..11 from bits 11..5.
- R8: A read with a parity mismatch sets bit 15 on the following clock and captures the failing address. With bit 14 clear the field shows address bits 17..11. With bit 14 set, bits 8..5 show address bits 21..18 and bits 11..9 read zero.
- R9: `bus_err` is high, together with `ack`, on a parity-error read only while CSR bit 0 is set. With bit 0 clear the flag still sets.
- R10: Once bit 15 is set, later parity errors leave the captured address unchanged until software clears bit 15.
- R11: Reset drives `ack` and `bus_err` low and clears every CSR bit, including the captured address.
- R12: `ack` is high exactly in the cycle after a cycle with `req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up / bus INIT) |
| csr_sel | input | 4 | Static CSR address select, word step |
| req | input | 1 | Request, one cycle per transfer |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 22 | Byte address |
| wdata | input | 16 | Write data |
| ack | output | 1 | Transfer done, one cycle after `req` |
| rdata | output | 16 | Read data, valid with `ack` |
| bus_err | output | 1 | Parity error reported on this read |

## Verification
The bench fills every populated row and checks reads against its own model, so a decoder that aliases banks, or strobes more than one, shows up as corrupted rows. It targets the unpopulated slots, the bytes just below and just past the span, and odd addresses. A design that let these reach storage, or ran the parity check on floating data, would return stored words or raise spurious errors. Words poisoned with the invert bit are read back with the enable on and off, and in both address views. A second error arriving while the flag is set must not move the capture. A design that kept re-latching, or that gated the flag with the enable, fails these checks. A mid-run reset must clear a fully loaded register.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 2;
  localparam int ST_W   = DATA_W + CHK_W;
  localparam int LAT_W  = 11;   // captured address bits 21..11

  typedef struct packed {
    logic flag;
    logic ext;
    logic wwp;
    logic pe_en;
  } csr_ctl_t;

  // even parity per byte: {high byte, low byte}
  function automatic logic [CHK_W-1:0] byte_par(input logic [DATA_W-1:0] d);
    return {^d[15:8], ^d[7:0]};
  endfunction

  // I/O-page word address of the CSR for a given select
  function automatic logic [ADDR_W-1:0] csr_addr(input logic [3:0] sel);
    return 22'h3FF440 + {17'd0, sel, 1'b0};
  endfunction

  // visible error-address field from the latch (latch[10:7]=a21..18, [6:0]=a17..11)
  function automatic logic [6:0] err_field(input logic [LAT_W-1:0] lat, input logic ext);
    return ext ? {3'b000, lat[10:7]} : lat[6:0];
  endfunction

endpackage

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int RW   = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            ras,
  input  logic            we,
  input  logic [RW-1:0]   row,
  input  logic [ST_W-1:0] wdata,
  output logic [ST_W-1:0] rdata
);

  logic [ST_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (ras) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end

endmodule

// File: rtl/pmc_array.sv
module pmc_array
  import pmc_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int POP_BANKS  = 8,
  parameter int BANK_WORDS = 128,
  localparam int RW        = $clog2(BANK_WORDS)
) (
  input  logic             clk,
  input  logic [BANKS-1:0] ras,
  input  logic             we,
  input  logic [RW-1:0]    row,
  input  logic [ST_W-1:0]  wdata,
  output logic [ST_W-1:0]  rdata
);

  logic [ST_W-1:0] contrib [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    if (b < POP_BANKS) begin : g_fit
      logic [ST_W-1:0] q;
      logic            sel_q;
      pmc_bank #(.WORDS(BANK_WORDS)) u_bank (
        .clk   (clk),
        .ras   (ras[b]),
        .we    (we),
        .row   (row),
        .wdata (wdata),
        .rdata (q)
      );
      always_ff @(posedge clk) sel_q <= ras[b] & ~we;
      assign contrib[b] = sel_q ? q : '0;
    end else begin : g_hole
      // empty slot: the shared read lines float high when strobed
      logic float_q;
      always_ff @(posedge clk) float_q <= ras[b] & ~we;
      assign contrib[b] = {ST_W{float_q}};
    end
  end

  // wired-OR of the bank outputs
  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) rdata |= contrib[b];
  end

endmodule

// File: rtl/pmc_csr.sv
module pmc_csr
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic             sw_flag,
  input  logic             sw_ext,
  input  logic [6:0]       sw_field,
  input  logic             sw_wwp,
  input  logic             sw_pe,
  input  logic             hw_err,
  input  logic [LAT_W-1:0] hw_addr,
  output csr_ctl_t         ctl,
  output logic [LAT_W-1:0] lat,
  output logic [DATA_W-1:0] rd_val
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      lat <= '0;
    end else begin
      if (sw_wr) begin
        ctl.flag  <= sw_flag;
        ctl.ext   <= sw_ext;
        ctl.wwp   <= sw_wwp;
        ctl.pe_en <= sw_pe;
        if (sw_ext) lat[10:7] <= sw_field[3:0];
        else        lat[6:0]  <= sw_field;
      end
      // hardware wins over a same-cycle software write
      if (hw_err) begin
        ctl.flag <= 1'b1;
        if (!ctl.flag) lat <= hw_addr;
      end
    end
  end

  assign rd_val = {ctl.flag, ctl.ext, 2'b00, err_field(lat, ctl.ext),
                   2'b00, ctl.wwp, 1'b0, ctl.pe_en};

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int          BANKS      = 8,
  parameter int          POP_BANKS  = 8,
  parameter int          BANK_WORDS = 128,
  parameter logic [21:0] MEM_BASE   = 22'h1D5400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  csr_sel,
  input  logic        req,
  input  logic        we,
  input  logic [21:0] addr,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        bus_err
);

  localparam int RW = $clog2(BANK_WORDS);
  localparam int BW = $clog2(BANKS);
  localparam int OW = RW + BW;                      // top bit of the word offset
  localparam logic [BANKS-1:0] POP_MASK = BANKS'((1 << POP_BANKS) - 1);

  // ---------------- decode ----------------
  logic [ADDR_W-1:0] off;
  logic              in_span, csr_hit, mem_hit, bank_here;
  logic [RW-1:0]     row;
  logic [BW-1:0]     bank;
  logic [BANKS-1:0]  ras;

  assign off       = addr - MEM_BASE;
  assign csr_hit   = req && (addr == csr_addr(csr_sel));
  assign in_span   = (addr >= MEM_BASE) && (off[ADDR_W-1:OW+1] == '0) && !off[0];
  assign mem_hit   = req && in_span && !csr_hit;
  assign row       = off[RW:1];
  assign bank      = off[OW:RW+1];
  assign bank_here = POP_MASK[bank];

  always_comb begin
    ras = '0;
    if (mem_hit) ras[bank] = 1'b1;
  end

  // ---------------- CSR ----------------
  csr_ctl_t          ctl;
  logic [LAT_W-1:0]  lat;
  logic [DATA_W-1:0] csr_val;
  logic              csr_wr, par_err;
  logic [LAT_W-1:0]  erra_q;

  assign csr_wr = csr_hit && we;

  pmc_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (csr_wr),
    .sw_flag  (wdata[15]),
    .sw_ext   (wdata[14]),
    .sw_field (wdata[11:5]),
    .sw_wwp   (wdata[2]),
    .sw_pe    (wdata[0]),
    .hw_err   (par_err),
    .hw_addr  (erra_q),
    .ctl      (ctl),
    .lat      (lat),
    .rd_val   (csr_val)
  );

  // ---------------- array ----------------
  logic [ST_W-1:0] st_w, arr_rd;

  assign st_w = {byte_par(wdata) ^ {CHK_W{ctl.wwp}}, wdata};

  pmc_array #(
    .BANKS      (BANKS),
    .POP_BANKS  (POP_BANKS),
    .BANK_WORDS (BANK_WORDS)
  ) u_arr (
    .clk   (clk),
    .ras   (ras),
    .we    (we),
    .row   (row),
    .wdata (st_w),
    .rdata (arr_rd)
  );

  // ---------------- response stage ----------------
  logic              ack_q, csr_rd_q, fill_q, mem_rd_q, here_q;
  logic [DATA_W-1:0] csrv_q;
  logic              chk_q, hole_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      csr_rd_q <= 1'b0;
      fill_q   <= 1'b0;
      mem_rd_q <= 1'b0;
      here_q   <= 1'b0;
      csrv_q   <= '0;
      erra_q   <= '0;
    end else begin
      ack_q    <= req;
      csr_rd_q <= csr_hit && !we;
      fill_q   <= req && !we && !csr_hit && !mem_hit;
      mem_rd_q <= mem_hit && !we;
      here_q   <= bank_here;
      if (csr_hit && !we) csrv_q <= csr_val;
      if (req) erra_q <= addr[ADDR_W-1:ADDR_W-LAT_W];
    end
  end

  assign chk_q   = mem_rd_q && here_q;
  assign hole_q  = mem_rd_q && !here_q;
  assign par_err = ack_q && chk_q &&
                   (arr_rd[ST_W-1:DATA_W] != byte_par(arr_rd[DATA_W-1:0]));

  assign ack     = ack_q;
  assign bus_err = par_err && ctl.pe_en;
  assign rdata   = csr_rd_q ? csrv_q : (fill_q ? '1 : arr_rd[DATA_W-1:0]);

  // named events for the checker
  logic err_flag, pe_on;
  assign err_flag = ctl.flag;
  assign pe_on    = ctl.pe_en;

endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk #(
  parameter int BANKS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             ack,
  input logic             bus_err,
  input logic [15:0]      rdata,
  input logic [BANKS-1:0] ras,
  input logic             par_err,
  input logic             err_flag,
  input logic             pe_on,
  input logic             csr_wr,
  input logic [10:0]      lat,
  input logic             hole_q
);

  assert_ack_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);

  assert_ack_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ras));

  assert_buserr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (ack && pe_on && par_err));

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> err_flag);

  assert_latch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !csr_wr) |=> ($stable(lat) && err_flag));

  assert_empty_bank_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hole_q) |-> (rdata == 16'hFFFF && !bus_err && !par_err));

endmodule

bind pmc_ctrl pmc_ctrl_chk #(.BANKS(BANKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .ack      (ack),
  .bus_err  (bus_err),
  .rdata    (rdata),
  .ras      (ras),
  .par_err  (par_err),
  .err_flag (err_flag),
  .pe_on    (pe_on),
  .csr_wr   (csr_wr),
  .lat      (lat),
  .hole_q   (hole_q)
);

// File: tb/sim_pmc_ctrl.sv
module sim_pmc_ctrl;

  localparam int          NB   = 8;
  localparam int          NPOP = 6;
  localparam int          NW   = 128;
  localparam logic [21:0] BASE = 22'h1D5400;
  localparam logic [3:0]  SEL  = 4'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  csr_sel = SEL;
  logic        req = 1'b0, we = 1'b0;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ack, bus_err;
  logic [15:0] rdata;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [15:0] model [NB*NW];

  always #10 clk = ~clk;   // 50 MHz

  pmc_ctrl #(.BANKS(NB), .POP_BANKS(NPOP), .BANK_WORDS(NW), .MEM_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata), .bus_err(bus_err)
  );

  // ---------- bench reference functions ----------
  function automatic logic [21:0] f_csr_at(input logic [3:0] s);
    return 22'o17772100 + 22'(2 * int'(s));
  endfunction

  function automatic logic [21:0] f_word(input int idx);
    return BASE + 22'(idx * 2);
  endfunction

  function automatic logic [15:0] f_csr(input logic flag, input logic ext,
                                        input logic [21:0] a, input logic wwp,
                                        input logic pe);
    logic [15:0] v;
    v = '0;
    if (flag) v = v | 16'h8000;
    if (ext)  v = v | 16'h4000 | (16'(a >> 18) & 16'h000F) << 5;
    else      v = v | ((16'(a >> 11) & 16'h007F) << 5);
    if (wwp)  v = v | 16'h0004;
    if (pe)   v = v | 16'h0001;
    return v;
  endfunction

  function automatic logic [15:0] f_expect(input int idx);
    return (idx / NW < NPOP) ? model[idx] : 16'hFFFF;
  endfunction

  // ---------- helpers ----------
  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [21:0] a, input logic [15:0] d,
                     output logic [15:0] r, output logic e, output logic k);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r = rdata; e = bus_err; k = ack;
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    logic [15:0] r; logic e, k;
    bus(1'b1, a, d, r, e, k);
  endtask

  task automatic rd(input logic [21:0] a, output logic [15:0] r, output logic e,
                    output logic k);
    bus(1'b0, a, 16'h0000, r, e, k);
  endtask

  initial begin : main
    logic [15:0] r; logic e, k;
    logic [21:0] a_csr, a_p2, a_p5;
    int i2, i5;
    void'($urandom(32'd20240611));
    a_csr = f_csr_at(SEL);

    // reset state, R11
    repeat (3) @(negedge clk);
    check(ack == 1'b0 && bus_err == 1'b0, "R11 outputs low in reset", {ack, bus_err}, 0);
    rst_n = 1'b1;
    rd(a_csr, r, e, k);
    check(r == 16'h0000, "R11 CSR clear after reset", r, 0);
    check(k == 1'b1, "R12 ack one cycle after req", k, 1);
    @(negedge clk);
    check(ack == 1'b0, "R12 ack drops without req", ack, 0);

    // CSR layout, R7
    wr(a_csr, 16'hFFFF);
    rd(a_csr, r, e, k);
    check(r == f_csr(1, 1, 22'h3C0000, 1, 1), "R7 all ones written", r, f_csr(1, 1, 22'h3C0000, 1, 1));
    wr(a_csr, 16'h0000);
    rd(a_csr, r, e, k);
    check(r == 16'h0000, "R7 all zeros written", r, 0);
    wr(a_csr, 16'h4000);
    rd(a_csr, r, e, k);
    check(r == 16'h4000, "R7 high view field written zero", r, 16'h4000);
    wr(a_csr, 16'h0AA0);
    rd(a_csr, r, e, k);
    check(r == 16'h0AA0, "R7 low field write", r, 16'h0AA0);
    wr(a_csr, 16'h0000);

    // CSR decode, R6
    wr(f_csr_at(SEL - 4'd1), 16'h0005);
    rd(f_csr_at(SEL - 4'd1), r, e, k);
    check(r == 16'hFFFF && !e, "R6 neighbour address reads ones", r, 16'hFFFF);
    rd(a_csr, r, e, k);
    check(r == 16'h0000, "R6 neighbour write ignored", r, 0);

    // fill populated banks, R1
    for (int idx = 0; idx < NPOP * NW; idx++) begin
      model[idx] = 16'($urandom);
      wr(f_word(idx), model[idx]);
    end
    for (int idx = NPOP * NW; idx < NB * NW; idx++) model[idx] = 16'hFFFF;
    for (int idx = 0; idx < NPOP * NW; idx++) begin
      rd(f_word(idx), r, e, k);
      check(k && r == model[idx] && !e, "R1 fill readback", {k, e, r}, {1'b1, 1'b0, model[idx]});
    end

    // parity patterns, R2
    for (int p = 0; p < 6; p++) begin
      logic [15:0] pat;
      pat = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'h0100 :
            (p == 3) ? 16'h0001 : (p == 4) ? 16'h8080 : 16'h7FFE;
      model[3] = pat;
      wr(f_word(3), pat);
      rd(f_word(3), r, e, k);
      check(r == pat && !e, "R2 pattern no parity error", {e, r}, {1'b0, pat});
    end

    // bank independence, R4
    model[5] = 16'h1111;
    model[NW * 3 + 5] = 16'h3333;
    wr(f_word(5), 16'h1111);
    wr(f_word(NW * 3 + 5), 16'h3333);
    rd(f_word(5), r, e, k);
    check(r == 16'h1111, "R4 bank0 row kept", r, 16'h1111);
    rd(f_word(NW * 3 + 5), r, e, k);
    check(r == 16'h3333, "R4 bank3 row kept", r, 16'h3333);

    // absent and unmapped, R5
    wr(f_word(NW * 6 + 10), 16'h0000);
    rd(f_word(NW * 6 + 10), r, e, k);
    check(r == 16'hFFFF && !e, "R5 absent bank reads ones", {e, r}, 17'h0FFFF);
    wr(BASE + 22'(NB * NW * 2), 16'hABCD);
    rd(BASE + 22'(NB * NW * 2), r, e, k);
    check(r == 16'hFFFF && !e, "R5 past span reads ones", {e, r}, 17'h0FFFF);
    wr(BASE - 22'd2, 16'hABCD);
    rd(BASE - 22'd2, r, e, k);
    check(r == 16'hFFFF && !e, "R5 below span reads ones", {e, r}, 17'h0FFFF);
    wr(BASE + 22'd1, 16'h1357);
    rd(BASE + 22'd1, r, e, k);
    check(r == 16'hFFFF && !e, "R5 odd address reads ones", {e, r}, 17'h0FFFF);
    rd(f_word(0), r, e, k);
    check(r == model[0], "R5 unmapped writes left row 0", r, model[0]);
    rd(a_csr, r, e, k);
    check(r == 16'h0000, "R5 no flag from unmapped reads", r, 0);

    // random mix, R1 R4 R5
    for (int n = 0; n < 400; n++) begin
      int idx;
      idx = int'($urandom_range(NB * NW - 1, 0));
      if ($urandom_range(1, 0) == 1) begin
        logic [15:0] d;
        d = 16'($urandom);
        if (idx / NW < NPOP) model[idx] = d;
        wr(f_word(idx), d);
      end else begin
        rd(f_word(idx), r, e, k);
        check(r == f_expect(idx) && !e, "R1 R4 R5 random read", r, f_expect(idx));
      end
    end

    // forced bad parity, R3 R8 R9 R10
    i2 = NW * 2 + 17; a_p2 = f_word(i2);
    i5 = NW * 5 + 40; a_p5 = f_word(i5);
    wr(a_csr, 16'h0004);
    wr(a_p2, 16'h1234);
    wr(a_p5, 16'hBEEF);
    wr(a_csr, 16'h0001);
    rd(a_p2, r, e, k);
    check(r == 16'h1234, "R3 poisoned data intact", r, 16'h1234);
    check(e == 1'b1, "R9 bus_err with enable", e, 1);
    rd(a_csr, r, e, k);
    check(r == f_csr(1, 0, a_p2, 0, 1), "R8 low view capture", r, f_csr(1, 0, a_p2, 0, 1));
    rd(a_p5, r, e, k);
    check(e == 1'b1, "R3 second poisoned word errs", e, 1);
    rd(a_csr, r, e, k);
    check(r == f_csr(1, 0, a_p2, 0, 1), "R10 capture held", r, f_csr(1, 0, a_p2, 0, 1));
    wr(a_csr, 16'h0000);
    rd(a_p5, r, e, k);
    check(e == 1'b0, "R9 no bus_err when disabled", e, 0);
    rd(a_csr, r, e, k);
    check(r == f_csr(1, 0, a_p5, 0, 0), "R8 R9 flag sets with enable off", r, f_csr(1, 0, a_p5, 0, 0));
    wr(a_csr, 16'h4001);
    rd(a_p2, r, e, k);
    check(e == 1'b1, "R9 bus_err in high view", e, 1);
    rd(a_csr, r, e, k);
    check(r == f_csr(1, 1, a_p2, 0, 1), "R8 high view capture", r, f_csr(1, 1, a_p2, 0, 1));
    wr(a_csr, 16'h0001);
    wr(a_p2, 16'h5678);
    rd(a_p2, r, e, k);
    check(r == 16'h5678 && !e, "R2 rewrite clears poison", {e, r}, 17'h05678);

    // reset mid-run, R11
    wr(a_csr, 16'hC005);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(a_csr, r, e, k);
    check(r == 16'h0000, "R11 reset clears loaded CSR", r, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule